// File: doc/BRIEF.md
# Clocked-to-1-of-4 Handshake Bridge

This bridge joins a clocked request/grant word interface to a channel that uses four-phase, return-to-neutral 1-of-4 signalling. In the send direction it takes a word from the clocked side and drives it out as a series of 2-bit digits. Each digit is placed on a group of four rails with exactly one rail high. The digit waits for the receiver's acknowledge, and the group then returns to all-low before the next digit. In the receive direction it reverses the process. It decodes incoming 1-of-4 digits, acknowledges each one, assembles a word and offers that word on a clocked request/grant port.

The channel wires are modelled synchronously. The rails are driven from registers and the incoming rails and acknowledge are sampled on the same fast clock as the word ports. The word width is a parameter and must be even. A word of `WORD_W` bits is carried as `WORD_W/2` digits, least significant digit first.

Top module: `quad_rail_bridge`

## Requirements
- R1: While `rst_ni` is low, and until the first word moves, `tx_rail_o` is 0000, `rx_ack_o` is 0, `m_req_o` is 0 and `s_gnt_o` is 1.
- R2: A digit of value v (0..3) is driven as `tx_rail_o` = 1 << v, so that only rail v is high. The neutral state is 0000.
- R3: Digit k of a sent word is bits [2k+1:2k], and digits go out in order k = 0, 1, ..., WORD_W/2-1. The first digit appears on `tx_rail_o` one clock after the accepting edge.
- R4: A driven digit holds stable while `tx_ack_i` is low. The rails go neutral one clock after `tx_ack_i` is seen high. No further digit is driven while `tx_ack_i` stays high.
- R5: A word is taken only at a rising edge with `s_req_i` and `s_gnt_o` both high. `s_gnt_o` is low from that edge until the last digit's acknowledge has fallen. While it is low, `s_req_i` and `s_data_i` have no effect.
- R6: `tx_rail_o` never has more than one rail high.
- R7: A non-neutral group on `rx_rail_i` raises `rx_ack_o` one clock later, provided no word is waiting at the receive port. `rx_ack_o` falls one clock after the group returns to 0000.
- R8: After WORD_W/2 received digits, `m_req_o` rises in the same clock that the last acknowledge falls. `m_data_o` holds the digits, the first received digit in bits [1:0]. Both hold stable until `m_gnt_i` is high.
- R9: While `m_req_o` is high, no incoming digit is acknowledged.
- R10: A received group with two or more rails high is still acknowledged, and its digit is stored as 00. `m_err_o` is 1 with the resulting word. The next word starts with the error cleared.
- R11: A received word is handed over at an edge with `m_req_o` and `m_gnt_i` both high, and `m_req_o` is low one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_req_i | input | 1 | Clocked side offers a word to send |
| s_gnt_o | output | 1 | Bridge can take a word this edge |
| s_data_i | input | WORD_W | Word to send |
| tx_rail_o | output | 4 | Outgoing 1-of-4 digit group |
| tx_ack_i | input | 1 | Acknowledge from the far receiver |
| rx_rail_i | input | 4 | Incoming 1-of-4 digit group |
| rx_ack_o | output | 1 | Acknowledge to the far sender |
| m_req_o | output | 1 | Received word is available |
| m_gnt_i | input | 1 | Clocked side takes the received word |
| m_data_o | output | WORD_W | Received word |
| m_err_o | output | 1 | Received word contained a multi-hot group |

## Verification
The hardest condition to reach from the ports is an incoming digit that arrives while an assembled word is still waiting for its grant. The receiver must hold its acknowledge low then, even though the rails are valid. The bench sets this up by holding `m_gnt_i` low after chosen words and raising a legal group on `rx_rail_i` during the wait, then watching `rx_ack_o`. On the send side, the bench acts as the far receiver. It varies the acknowledge delay and the time acknowledge stays high for each digit of every 8-bit value, and it keeps request high with changed data throughout serialisation, so that a stray acceptance would show up on the rails.

// File: rtl/qr_pkg.sv
package qr_pkg;
  localparam int unsigned RAIL_W = 4;
  typedef logic [RAIL_W-1:0] rail_t;

  typedef enum logic [1:0] {TX_IDLE, TX_DRIVE, TX_RTZ} tx_state_e;
  typedef enum logic [1:0] {RX_COLLECT, RX_ACKED, RX_OUT} rx_state_e;

  function automatic rail_t enc_digit(input logic [1:0] d);
    return rail_t'(1) << d;
  endfunction
endpackage

// File: rtl/qr_group_dec.sv
module qr_group_dec
  import qr_pkg::*;
(
  input  rail_t      rail_i,
  output logic       valid_o,
  output logic       multi_o,
  output logic [1:0] digit_o
);
  always_comb begin
    valid_o = |rail_i;
    multi_o = (rail_i[0] & rail_i[1]) | (rail_i[0] & rail_i[2]) |
              (rail_i[0] & rail_i[3]) | (rail_i[1] & rail_i[2]) |
              (rail_i[1] & rail_i[3]) | (rail_i[2] & rail_i[3]);
    if (multi_o) digit_o = 2'b00;
    else         digit_o = {rail_i[3] | rail_i[2], rail_i[3] | rail_i[1]};
  end
endmodule

// File: rtl/qr_tx_ser.sv
module qr_tx_ser
  import qr_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              s_req_i,
  output logic              s_gnt_o,
  input  logic [WORD_W-1:0] s_data_i,
  output rail_t             rail_o,
  input  logic              ack_i
);
  localparam int unsigned DIGITS = WORD_W / 2;
  localparam int unsigned IDX_W  = (DIGITS > 1) ? $clog2(DIGITS) : 1;

  tx_state_e         state_q;
  logic [WORD_W-1:0] word_q;
  logic [IDX_W-1:0]  idx_q;
  rail_t             rail_q;
  logic              last_digit;

  assign last_digit = (idx_q == IDX_W'(DIGITS - 1));
  assign s_gnt_o    = (state_q == TX_IDLE);
  assign rail_o     = rail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      word_q  <= '0;
      idx_q   <= '0;
      rail_q  <= '0;
    end else begin
      unique case (state_q)
        TX_IDLE: if (s_req_i) begin
          word_q  <= s_data_i >> 2;
          idx_q   <= '0;
          rail_q  <= enc_digit(s_data_i[1:0]);
          state_q <= TX_DRIVE;
        end
        TX_DRIVE: if (ack_i) begin
          rail_q  <= '0;
          state_q <= TX_RTZ;
        end
        TX_RTZ: if (!ack_i) begin
          if (last_digit) begin
            state_q <= TX_IDLE;
          end else begin
            idx_q   <= idx_q + 1'b1;
            rail_q  <= enc_digit(word_q[1:0]);
            word_q  <= word_q >> 2;
            state_q <= TX_DRIVE;
          end
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/qr_rx_deser.sv
module qr_rx_deser
  import qr_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  rail_t             rail_i,
  output logic              ack_o,
  output logic              m_req_o,
  input  logic              m_gnt_i,
  output logic [WORD_W-1:0] m_data_o,
  output logic              m_err_o
);
  localparam int unsigned DIGITS = WORD_W / 2;
  localparam int unsigned IDX_W  = (DIGITS > 1) ? $clog2(DIGITS) : 1;

  rx_state_e         state_q;
  logic [WORD_W-1:0] word_q;
  logic [IDX_W-1:0]  idx_q;
  logic              ack_q;
  logic              err_q;
  logic              grp_valid;
  logic              grp_multi;
  logic [1:0]        grp_digit;
  logic              last_digit;

  qr_group_dec i_dec (
    .rail_i  (rail_i),
    .valid_o (grp_valid),
    .multi_o (grp_multi),
    .digit_o (grp_digit)
  );

  assign last_digit = (idx_q == IDX_W'(DIGITS - 1));
  assign ack_o      = ack_q;
  assign m_req_o    = (state_q == RX_OUT);
  assign m_data_o   = word_q;
  assign m_err_o    = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_COLLECT;
      word_q  <= '0;
      idx_q   <= '0;
      ack_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        RX_COLLECT: if (grp_valid) begin
          // shift in from the top: first digit lands in [1:0]
          word_q  <= {grp_digit, word_q[WORD_W-1:2]};
          err_q   <= err_q | grp_multi;
          ack_q   <= 1'b1;
          state_q <= RX_ACKED;
        end
        RX_ACKED: if (!grp_valid) begin
          ack_q <= 1'b0;
          if (last_digit) begin
            state_q <= RX_OUT;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= RX_COLLECT;
          end
        end
        RX_OUT: if (m_gnt_i) begin
          idx_q   <= '0;
          err_q   <= 1'b0;
          state_q <= RX_COLLECT;
        end
        default: state_q <= RX_COLLECT;
      endcase
    end
  end
endmodule

// File: rtl/quad_rail_bridge.sv
module quad_rail_bridge
  import qr_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              s_req_i,
  output logic              s_gnt_o,
  input  logic [WORD_W-1:0] s_data_i,
  output logic [3:0]        tx_rail_o,
  input  logic              tx_ack_i,
  input  logic [3:0]        rx_rail_i,
  output logic              rx_ack_o,
  output logic              m_req_o,
  input  logic              m_gnt_i,
  output logic [WORD_W-1:0] m_data_o,
  output logic              m_err_o
);
  rail_t tx_rail;

  qr_tx_ser #(.WORD_W(WORD_W)) i_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .s_req_i  (s_req_i),
    .s_gnt_o  (s_gnt_o),
    .s_data_i (s_data_i),
    .rail_o   (tx_rail),
    .ack_i    (tx_ack_i)
  );

  assign tx_rail_o = tx_rail;

  qr_rx_deser #(.WORD_W(WORD_W)) i_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rail_i   (rx_rail_i),
    .ack_o    (rx_ack_o),
    .m_req_o  (m_req_o),
    .m_gnt_i  (m_gnt_i),
    .m_data_o (m_data_o),
    .m_err_o  (m_err_o)
  );
endmodule

// File: rtl/quad_rail_bridge_chk.sv
module quad_rail_bridge_chk #(
  parameter int unsigned WORD_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              s_req_i,
  input logic              s_gnt_o,
  input logic [WORD_W-1:0] s_data_i,
  input logic [3:0]        tx_rail_o,
  input logic              tx_ack_i,
  input logic [3:0]        rx_rail_i,
  input logic              rx_ack_o,
  input logic              m_req_o,
  input logic              m_gnt_i,
  input logic [WORD_W-1:0] m_data_o,
  input logic              m_err_o
);
  assert_tx_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tx_rail_o));

  assert_tx_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_rail_o != 4'b0 && !tx_ack_i) |=> $stable(tx_rail_o));

  assert_tx_rtz_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_rail_o != 4'b0 && tx_ack_i) |=> (tx_rail_o == 4'b0));

  assert_tx_wait_ack_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!s_gnt_o && tx_rail_o == 4'b0 && tx_ack_i) |=> (tx_rail_o == 4'b0));

  assert_tx_accept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_req_i && s_gnt_o) |=> (!s_gnt_o && tx_rail_o != 4'b0));

  assert_tx_no_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_gnt_o && !s_req_i) |=> (s_gnt_o && tx_rail_o == 4'b0));

  assert_rx_ack_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_rail_i != 4'b0 && !rx_ack_o && !m_req_o) |=> rx_ack_o);

  assert_rx_ack_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_ack_o && rx_rail_i == 4'b0) |=> !rx_ack_o);

  assert_rx_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_req_o && !m_gnt_i) |=> (m_req_o && $stable(m_data_o) && $stable(m_err_o)));

  assert_rx_backpressure_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_req_o && !m_gnt_i) |=> !rx_ack_o);

  assert_rx_handover_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_req_o && m_gnt_i) |=> !m_req_o);
endmodule

bind quad_rail_bridge quad_rail_bridge_chk #(.WORD_W(WORD_W)) i_chk (.*);

// File: tb/test_quad_rail_bridge.sv
module test_quad_rail_bridge;
  localparam int unsigned WORD_W = 8;
  localparam int unsigned DIGITS = WORD_W / 2;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              s_req_i = 1'b0;
  logic              s_gnt_o;
  logic [WORD_W-1:0] s_data_i = '0;
  logic [3:0]        tx_rail_o;
  logic              tx_ack_i = 1'b0;
  logic [3:0]        rx_rail_i = 4'b0;
  logic              rx_ack_o;
  logic              m_req_o;
  logic              m_gnt_i = 1'b0;
  logic [WORD_W-1:0] m_data_o;
  logic              m_err_o;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  quad_rail_bridge #(.WORD_W(WORD_W)) i_quad_rail_bridge (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] onehot(input int v);
    return 4'(1 << (v & 3));
  endfunction

  task automatic nclk();
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  // send one word and act as the far receiver; dly/hold vary ack timing
  task automatic send_word(input int w);
    nclk();
    check("R5 grant idle", 32'(s_gnt_o), 1);
    s_req_i  = 1'b1;
    s_data_i = WORD_W'(w);
    nclk();
    // keep request high with other data: must be ignored while grant low
    s_data_i = ~WORD_W'(w);
    check("R5 grant low after accept", 32'(s_gnt_o), 0);
    for (int k = 0; k < DIGITS; k++) begin
      int d = (w >> (2 * k)) & 3;
      int dly = (w + k) % 3;
      int hold = (w >> k) & 1;
      check("R2 R3 digit on rails", 32'(tx_rail_o), 32'(onehot(d)));
      for (int j = 0; j < dly; j++) begin
        nclk();
        check("R4 digit held while ack low", 32'(tx_rail_o), 32'(onehot(d)));
      end
      tx_ack_i = 1'b1;
      nclk();
      check("R4 neutral after ack", 32'(tx_rail_o), 0);
      for (int j = 0; j < hold; j++) begin
        nclk();
        check("R4 no digit while ack high", 32'(tx_rail_o), 0);
      end
      tx_ack_i = 1'b0;
      if (k == DIGITS - 1) s_req_i = 1'b0;
      nclk();
      if (k != DIGITS - 1) check("R5 grant low mid-word", 32'(s_gnt_o), 0);
    end
    check("R5 grant back after last ack", 32'(s_gnt_o), 1);
    check("R6 rails neutral at end", 32'(tx_rail_o), 0);
  endtask

  // present one group, complete its handshake
  task automatic recv_group(input logic [3:0] grp);
    rx_rail_i = grp;
    nclk();
    check("R7 R10 ack raised", 32'(rx_ack_o), 1);
    rx_rail_i = 4'b0;
    nclk();
    check("R7 ack dropped", 32'(rx_ack_o), 0);
  endtask

  task automatic take_word(input int exp_w, input bit exp_err, input int wait_c, input bit press);
    check("R8 word offered", 32'(m_req_o), 1);
    check("R8 R10 word value", 32'(m_data_o), 32'(exp_w));
    check("R10 error flag", 32'(m_err_o), 32'(exp_err));
    if (press) rx_rail_i = onehot(2);
    for (int j = 0; j < wait_c; j++) begin
      nclk();
      check("R8 held until grant", 32'(m_data_o), 32'(exp_w));
      check("R8 req held", 32'(m_req_o), 1);
      if (press) check("R9 no ack while word waits", 32'(rx_ack_o), 0);
    end
    rx_rail_i = 4'b0;
    m_gnt_i = 1'b1;
    nclk();
    m_gnt_i = 1'b0;
    check("R11 req drops after grant", 32'(m_req_o), 0);
  endtask

  initial begin
    nclk();
    check("R1 rails in reset", 32'(tx_rail_o), 0);
    check("R1 rx ack in reset", 32'(rx_ack_o), 0);
    check("R1 grant in reset", 32'(s_gnt_o), 1);
    check("R1 m_req in reset", 32'(m_req_o), 0);
    nclk();
    rst_ni = 1'b1;
    s_data_i = 8'hA5;
    for (int j = 0; j < 3; j++) begin
      nclk();
      check("R5 no word without req", 32'(tx_rail_o), 0);
      check("R1 rx ack idle", 32'(rx_ack_o), 0);
    end

    for (int w = 0; w < (1 << WORD_W); w++) send_word(w);

    // multi-hot groups at each position (R10)
    for (int p = 3; p < 16; p++) begin
      int ones = (p & 1) + ((p >> 1) & 1) + ((p >> 2) & 1) + ((p >> 3) & 1);
      if (ones > 1) begin
        int pos = p % DIGITS;
        int base = (p * 37) & ((1 << WORD_W) - 1);
        int exp_w = base & ~(3 << (2 * pos));
        for (int k = 0; k < DIGITS; k++) begin
          if (k == pos) recv_group(4'(p));
          else recv_group(onehot(base >> (2 * k)));
        end
        take_word(exp_w, 1'b1, p % 3, 1'b0);
      end
    end

    for (int w = 0; w < (1 << WORD_W); w++) begin
      for (int k = 0; k < DIGITS; k++) recv_group(onehot(w >> (2 * k)));
      take_word(w, 1'b0, (w % 8 == 0) ? 3 : w % 3, (w % 8 == 0));
    end

    done = 1'b1;
    finish_run();
  end
endmodule